// File: doc/BRIEF.md
# Indexed Display-Mode Register Interface

This block gives a host a two-port window onto a small bank of 16-bit registers that describe a linear-framebuffer graphics mode. One port holds a register number; the other port reads or writes the register that number points at. Every data write is screened by the target register. An unacceptable value is thrown away without any sign to the host, and some values are rewritten into a canonical form before they are stored.

When the host writes the mode register with its run bit set, the block fixes the rest of the mode. It copies the visible size into the virtual size, zeroes both pan offsets and resets the display start address. It also works out how many bytes one scan line takes. Unless the host asked for the screen to be left alone, it raises a one-cycle request to clear the visible area and gives the length of that area in bytes. The memory clear and the pixel output are handled by other logic, which reads this block's outputs.

Top module: `dispmode_regs`

## Requirements
- R1: With `host_sel`=0, a write stores all 16 bits of `host_wdata` as the current register number. A read with `host_sel`=0 returns the number last stored.
- R2: With `host_sel`=1, `host_rdata` returns the selected register at register numbers 0 to 9. The numbering is: 0 identity, 1 width, 2 height, 3 depth, 4 mode, 5 bank, 6 virtual width, 7 virtual height, 8 horizontal offset, 9 vertical offset. At number 10 or above, reads return 0 and writes change nothing.
- R3: The identity register takes only 0xB0C0, 0xB0C1 or 0xB0C2 and ignores any other value.
- R4: A width write is dropped if its value is above 1024 or is not a multiple of 8. A height write is dropped if its value is above 768. `res_x` and `res_y` show the two registers.
- R5: A depth write of 0 is stored as 8. Of the other values, only 4, 8, 15, 16, 24 and 32 are kept. `depth` shows the register.
- R6: A bank write keeps bits 7:0 and stores zeros in bits 15:8.
- R7: A mode write is always stored. Bit 0 drives `mode_on` and bit 6 drives `lfb_on`. When bit 0 is written as 1, virtual width and height take the current width and height, both offsets become 0, and `start_addr` becomes 0.
- R8: A mode write with bit 0 set loads `stride` with width/2 at depth 4, and with width × ceil(depth/8) at any other depth. At other times `stride` holds its value.
- R9: A mode write with bit 0 set loads `clr_len` with height × the new stride. It also pulses `clr_req` high for exactly one cycle, unless bit 7 of the written value is 1. `clr_req` is never high at any other time.
- R10: Reset sets the identity register to 0xB0C0, the other registers and the register number to 0, and `stride`, `start_addr`, `clr_len` and `clr_req` to 0.
- R11: Register state and outputs change on the clock edge that takes the write, and are seen from the next cycle on. `host_rdata` is combinational from `host_sel` and the current register number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_sel | input | 1 | 0 selects the register-number port, 1 the data port |
| host_wr | input | 1 | Write strobe for the selected port |
| host_wdata | input | 16 | Write value |
| host_rdata | output | 16 | Read value of the selected port |
| res_x | output | 16 | Width register |
| res_y | output | 16 | Height register |
| depth | output | 16 | Bits-per-pixel register |
| mode_on | output | 1 | Mode register bit 0 |
| lfb_on | output | 1 | Mode register bit 6 |
| stride | output | 16 | Bytes per scan line, set on enable |
| start_addr | output | 32 | Display start address, set on enable |
| clr_req | output | 1 | One-cycle request to clear the visible area |
| clr_len | output | 32 | Byte length of the area to clear |

## Verification
Every stored value, along with `stride`, `clr_len`, `mode_on`, `lfb_on` and the `clr_req` pulse, must be visible one cycle after the edge that takes the write. `host_rdata` must follow a change of `host_sel` within the same cycle. The bench drives inputs on the falling edge. A behavioural model updates on each rising edge, and every output is compared 2 ns after that edge, so registered results are compared in exactly the cycle they are due. Directed checks sample at the falling edge right after a write, which is where a correct `clr_req` pulse is high and where it must be low again one cycle later.

// File: rtl/dispmode_regs.sv
module dispmode_regs #(
  parameter int DW    = 16,
  parameter int NREG  = 10,
  parameter int MAX_X = 1024,
  parameter int MAX_Y = 768,
  parameter int SW    = 16,
  parameter int AW    = 32,
  parameter int LW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_sel,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic [DW-1:0] res_x,
  output logic [DW-1:0] res_y,
  output logic [DW-1:0] depth,
  output logic          mode_on,
  output logic          lfb_on,
  output logic [SW-1:0] stride,
  output logic [AW-1:0] start_addr,
  output logic          clr_req,
  output logic [LW-1:0] clr_len
);
  localparam int IW = $clog2(NREG);
  localparam int IX_ID = 0, IX_XRES = 1, IX_YRES = 2, IX_BPP = 3, IX_MODE = 4;
  localparam int IX_BANK = 5, IX_VW = 6, IX_VH = 7, IX_XOFF = 8, IX_YOFF = 9;
  localparam logic [DW-1:0] ID_A = DW'(16'hB0C0);
  localparam logic [DW-1:0] ID_B = DW'(16'hB0C1);
  localparam logic [DW-1:0] ID_C = DW'(16'hB0C2);

  logic [DW-1:0] idx_q;
  logic [DW-1:0] rf [NREG];
  logic [DW-1:0] val_n;
  logic          wr_ok;

  wire idx_ok  = idx_q < DW'(NREG);
  wire data_wr = host_wr & host_sel & idx_ok;
  wire en_go   = data_wr & wr_ok & (idx_q == DW'(IX_MODE)) & host_wdata[0];

  always_comb begin
    val_n = host_wdata;
    wr_ok = 1'b1;
    case (idx_q)
      DW'(IX_ID):   wr_ok = (host_wdata == ID_A) || (host_wdata == ID_B) || (host_wdata == ID_C);
      DW'(IX_XRES): wr_ok = (host_wdata <= DW'(MAX_X)) && (host_wdata[2:0] == 3'd0);
      DW'(IX_YRES): wr_ok = host_wdata <= DW'(MAX_Y);
      DW'(IX_BPP): begin
        if (host_wdata == '0) val_n = DW'(8);
        wr_ok = (val_n == DW'(4))  || (val_n == DW'(8))  || (val_n == DW'(15)) ||
                (val_n == DW'(16)) || (val_n == DW'(24)) || (val_n == DW'(32));
      end
      DW'(IX_BANK): val_n = {{(DW-8){1'b0}}, host_wdata[7:0]};
      default: ;
    endcase
  end

  wire [DW-1:0] bpp_sum  = rf[IX_BPP] + DW'(7);
  wire [SW-1:0] stride_n = (rf[IX_BPP] == DW'(4)) ? SW'(rf[IX_XRES] >> 1)
                                                  : SW'(rf[IX_XRES]) * SW'(bpp_sum >> 3);
  wire [LW-1:0] len_n    = LW'(rf[IX_YRES]) * LW'(stride_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q      <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= (i == IX_ID) ? ID_A : '0;
      stride     <= '0;
      start_addr <= '0;
      clr_req    <= 1'b0;
      clr_len    <= '0;
    end else begin
      clr_req <= 1'b0;
      if (host_wr && !host_sel) idx_q <= host_wdata;
      if (data_wr && wr_ok) rf[idx_q[IW-1:0]] <= val_n;
      if (en_go) begin
        rf[IX_VW]   <= rf[IX_XRES];
        rf[IX_VH]   <= rf[IX_YRES];
        rf[IX_XOFF] <= '0;
        rf[IX_YOFF] <= '0;
        stride      <= stride_n;
        start_addr  <= '0;
        clr_len     <= len_n;
        clr_req     <= ~host_wdata[7];
      end
    end
  end

  assign host_rdata = !host_sel ? idx_q : (idx_ok ? rf[idx_q[IW-1:0]] : '0);
  assign res_x   = rf[IX_XRES];
  assign res_y   = rf[IX_YRES];
  assign depth   = rf[IX_BPP];
  assign mode_on = rf[IX_MODE][0];
  assign lfb_on  = rf[IX_MODE][6];

  a_r3_id_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (rf[IX_ID] == ID_A) || (rf[IX_ID] == ID_B) || (rf[IX_ID] == ID_C));
  a_r4_width_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (res_x <= DW'(MAX_X)) && (res_x[2:0] == 3'd0));
  a_r4_height_legal: assert property (@(posedge clk) disable iff (!rst_n)
    res_y <= DW'(MAX_Y));
  a_r5_depth_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (depth == '0) || (depth == DW'(4)) || (depth == DW'(8)) || (depth == DW'(15)) ||
    (depth == DW'(16)) || (depth == DW'(24)) || (depth == DW'(32)));
  a_r8_stride_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(host_wr && host_sel && idx_q == DW'(IX_MODE) && host_wdata[0]) |-> $stable(stride));
  a_r9_clr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |-> $past(host_wr && host_sel && idx_q == DW'(IX_MODE) && host_wdata[0] && !host_wdata[7]));
  a_r7_enable_zeroes_offsets: assert property (@(posedge clk) disable iff (!rst_n)
    $past(host_wr && host_sel && idx_q == DW'(IX_MODE) && host_wdata[0]) |->
      (rf[IX_XOFF] == '0) && (rf[IX_YOFF] == '0) && mode_on);
endmodule

// File: tb/tb_dispmode_regs.sv
`timescale 1ns/1ps
module tb_dispmode_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0;
  logic        host_wr = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata, res_x, res_y, depth, stride;
  logic        mode_on, lfb_on, clr_req;
  logic [31:0] start_addr, clr_len;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  dispmode_regs dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .res_x(res_x), .res_y(res_y),
    .depth(depth), .mode_on(mode_on), .lfb_on(lfb_on), .stride(stride),
    .start_addr(start_addr), .clr_req(clr_req), .clr_len(clr_len)
  );

  logic [15:0] m [10];
  logic [15:0] m_idx;
  int          m_stride, m_len;
  logic        m_clr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 10; i++) m[i] = 16'h0;
      m[0] = 16'hB0C0;
      m_idx = 0; m_stride = 0; m_len = 0; m_clr = 0;
    end else begin
      m_clr = 0;
      if (host_wr && !host_sel) m_idx = host_wdata;
      else if (host_wr && m_idx < 10) begin
        automatic int  v  = host_wdata;
        automatic bit  ok = 1;
        case (m_idx)
          0: ok = (v == 'hB0C0) || (v == 'hB0C1) || (v == 'hB0C2);
          1: ok = (v <= 1024) && (v % 8 == 0);
          2: ok = (v <= 768);
          3: begin
            if (v == 0) v = 8;
            ok = (v == 4) || (v == 8) || (v == 15) || (v == 16) || (v == 24) || (v == 32);
          end
          4: if (v % 2 == 1) begin
            m_stride = (m[3] == 4) ? m[1] / 2 : m[1] * ((m[3] + 7) / 8);
            m_len = m[2] * m_stride;
            m[6] = m[1]; m[7] = m[2]; m[8] = 0; m[9] = 0;
            m_clr = ((v / 128) % 2) == 0;
          end
          5: v = v % 256;
          default: ;
        endcase
        if (ok) m[m_idx] = 16'(v);
      end
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  always begin
    @(posedge clk);
    #2;
    if (rst_n) begin
      chk("R1/R2", "rdata", host_rdata,
          host_sel ? ((m_idx < 10) ? m[m_idx] : 0) : m_idx);
      chk("R4", "res_x", res_x, m[1]);
      chk("R4", "res_y", res_y, m[2]);
      chk("R5", "depth", depth, m[3]);
      chk("R7", "mode_on", mode_on, m[4][0]);
      chk("R7", "lfb_on", lfb_on, m[4][6]);
      chk("R8", "stride", stride, m_stride);
      chk("R7", "start_addr", start_addr, 0);
      chk("R9", "clr_req", clr_req, m_clr);
      chk("R9", "clr_len", clr_len, m_len);
    end
  end

  task automatic put(input bit sel, input logic [15:0] d);
    @(negedge clk);
    host_sel = sel; host_wr = 1'b1; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic wreg(input int ix, input logic [15:0] d);
    put(1'b0, 16'(ix));
    put(1'b1, d);
  endtask

  task automatic rreg(input int ix, input string req, input longint exp);
    put(1'b0, 16'(ix));
    host_sel = 1'b1;
    #1;
    chk(req, "read", host_rdata, exp);
  endtask

  task automatic stimulus();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "reset id", host_rdata, 0);
    host_sel = 1'b1; #1;
    chk("R10", "reset id data", host_rdata, 16'hB0C0);
    chk("R10", "reset stride", stride, 0);
    chk("R10", "reset clr_req", clr_req, 0);
    wreg(0, 16'hB0C5);  rreg(0, "R3", 16'hB0C0);
    wreg(0, 16'hB0C2);  rreg(0, "R3", 16'hB0C2);
    wreg(1, 16'd1025);  chk("R4", "x too big", res_x, 0);
    wreg(1, 16'd1020);  chk("R4", "x unaligned", res_x, 0);
    wreg(1, 16'd1024);  chk("R4", "x at limit", res_x, 1024);
    wreg(1, 16'd640);   chk("R11", "x next cycle", res_x, 640);
    wreg(2, 16'd769);   chk("R4", "y too big", res_y, 0);
    wreg(2, 16'd768);   chk("R4", "y at limit", res_y, 768);
    wreg(2, 16'd480);
    wreg(3, 16'd0);     chk("R5", "bpp zero", depth, 8);
    wreg(3, 16'd7);     chk("R5", "bpp illegal", depth, 8);
    wreg(3, 16'd24);    chk("R5", "bpp 24", depth, 24);
    wreg(5, 16'h1234);  rreg(5, "R6", 16'h0034);
    wreg(12, 16'd5);    rreg(12, "R2", 0);
    host_sel = 1'b0; #1;
    chk("R1", "index readback", host_rdata, 12);
    wreg(8, 16'd5);     rreg(8, "R2", 5);
    wreg(4, 16'h0041);
    chk("R9", "clr pulse", clr_req, 1);
    chk("R9", "clr len", clr_len, 921600);
    chk("R8", "stride 24bpp", stride, 1920);
    chk("R7", "lfb", lfb_on, 1);
    @(negedge clk);
    chk("R9", "pulse one cycle", clr_req, 0);
    rreg(6, "R7", 640);
    rreg(7, "R7", 480);
    rreg(8, "R7", 0);
    wreg(3, 16'd4);
    wreg(4, 16'h0081);
    chk("R9", "clr suppressed", clr_req, 0);
    chk("R8", "stride 4bpp", stride, 320);
    chk("R9", "len 4bpp", clr_len, 153600);
    wreg(4, 16'h0000);
    chk("R7", "mode off", mode_on, 0);
    chk("R8", "stride held", stride, 320);
    for (int n = 0; n < 600; n++) begin
      automatic int r = $urandom_range(0, 9);
      automatic logic [15:0] d;
      case (r)
        0: d = 16'($urandom_range(0, 11));
        1: d = 16'($urandom_range(0, 130) * 8);
        2: d = 16'($urandom_range(0, 800));
        3: d = 16'($urandom_range(0, 33));
        4: d = 16'hB0C0 + 16'($urandom_range(0, 3));
        5: d = 16'($urandom_range(0, 1) | ($urandom_range(0, 3) << 6));
        default: d = 16'($urandom);
      endcase
      put(($urandom_range(0, 2) != 0), d);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    fork
      stimulus();
      begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule